// File: doc/BRIEF.md
# Memory Access Bus Sequencer

This block sits between a processor core and one shared bus that serves both memory cells and memory-mapped I/O ports. The core hands over a fetch or a store as a single request. The block latches the address into an address holding register. For a store it also latches the value into a data holding register. It then runs a fixed, multi-cycle bus cycle with separate read and write strobes.

The bus cycle has three parts. In the setup cycle the address is driven, and for a store the data is driven too. In the following cycle the strobe is raised. It stays high for as long as the target holds its ready input low. After that comes a release cycle: the strobe is already low, while the address and data are still driven. In the release cycle a one-clock completion pulse is given. On a fetch, the data holding register then holds the word that the target returned.

I/O ports are selected only by address. An address whose top bits are all ones is flagged on a memory-versus-I/O control line. Apart from that flag, it is treated exactly like a memory cell. The block only drives the address bus and never samples it.

Top module: `mem_bus_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, both strobes are 0, and `bus_addr` and `bus_wdata` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the cycle after `done`. Request inputs presented while it is 0 are ignored.
- R3: In a fetch, the address appears on `bus_addr` one cycle before `bus_rd` rises. The address is held unchanged while `bus_rd` is high. `bus_rd` and `bus_wr` are never high together.
- R4: A fetch captures `bus_rdata` at the last strobe cycle, the one in which `bus_ready` is 1. `rdata` shows that value in the cycle where `done` is 1.
- R5: In a store, `bus_addr` and `bus_wdata` both carry the request in the setup cycle. `bus_wr` rises in the following cycle.
- R6: `bus_wr` falls one cycle before the address and data leave the bus. That release cycle still drives the same address and data.
- R7: While `bus_ready` is 0 in a strobe cycle, the strobe stays high and the cycle is extended. With k wait cycles, the strobe is high for k+1 cycles.
- R8: `bus_wdata` is 0 in every cycle that is not part of a store.
- R9: `bus_rnw` is 1 except during a store cycle. `bus_io` is 1 during a cycle whose address has its top `IO_TAG_W` bits (default 4) all ones, and 0 otherwise.
- R10: A store overwrites the addressed cell, so a later fetch returns the new value. A fetch leaves the cell unchanged, so two fetches in a row return the same value.
- R11: `done` is a single-cycle pulse. It is followed by a cycle in which the bus is idle: `bus_addr` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_write | input | 1 | 1 for a store, 0 for a fetch |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store value |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data holding register contents |
| bus_addr | output | ADDR_W | Address bus, 0 when idle |
| bus_wdata | output | DATA_W | Write data bus, 0 outside stores |
| bus_rdata | input | DATA_W | Read data from target |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rnw | output | 1 | Read/write indication, 1 = not writing |
| bus_io | output | 1 | Address lies in the I/O region |
| bus_ready | input | 1 | Target ready, sampled in strobe cycles |

## Verification
The phase register drives every output. If it holds a wrong value, the port pattern of the very next cycle breaks: a strobe appears with no setup cycle before it, the address drops while a strobe is still high, or `done` is missing or lasts more than one cycle. A latch enable fault in the address or data holding registers shows at the ports one cycle after the request is taken, as a wrong `bus_addr` or `bus_wdata`. A wrong capture condition shows in the `done` cycle, as wrong `rdata` compared with the bench's shadow memory. A wrong wait-state decision shows as a strobe whose length differs from k+1.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_RELS = 2'd3
  } mbs_phase_e;

  // next bus phase from the current one, a new start and target readiness
  function automatic mbs_phase_e phase_step(mbs_phase_e cur, logic start, logic tgt_ready);
    mbs_phase_e nxt;
    case (cur)
      PH_IDLE: nxt = start ? PH_ADDR : PH_IDLE;
      PH_ADDR: nxt = PH_STRB;
      PH_STRB: nxt = tgt_ready ? PH_RELS : PH_STRB;
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tgt_ready,
  output logic in_idle,
  output logic in_addr,
  output logic in_strobe,
  output logic in_release
);

  mbs_phase_e phase;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_step(phase, start, tgt_ready);
  end

  assign in_idle    = (phase == PH_IDLE);
  assign in_addr    = (phase == PH_ADDR);
  assign in_strobe  = (phase == PH_STRB);
  assign in_release = (phase == PH_RELS);

  // setup cycle is always followed by a strobe cycle (R3, R5)
  assert_setup_then_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr |=> in_strobe);

  // wait states keep the strobe phase (R7)
  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !tgt_ready) |=> in_strobe);

  // release lasts exactly one cycle (R11)
  assert_release_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_release |=> in_idle);

endmodule

// File: rtl/mbs_regs.sv
module mbs_regs #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int IO_TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic              is_write,
  output logic              is_io
);

  localparam int TAG_LSB = ADDR_W - IO_TAG_W;

  function automatic logic addr_in_io(logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:TAG_LSB];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar      <= '0;
      is_write <= 1'b0;
      is_io    <= 1'b0;
    end else if (load) begin
      mar      <= req_addr;
      is_write <= req_write;
      is_io    <= addr_in_io(req_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  mdr <= '0;
    else if (load && req_write)  mdr <= req_wdata;
    else if (capture)            mdr <= bus_rdata;
  end

  // address register changes only when a request is taken (R2)
  assert_mar_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mar));

endmodule

// File: rtl/mbs_bus_drive.sv
module mbs_bus_drive #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              in_addr,
  input  logic              in_strobe,
  input  logic              in_release,
  input  logic [ADDR_W-1:0] mar,
  input  logic [DATA_W-1:0] mdr,
  input  logic              is_write,
  input  logic              is_io,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_rnw,
  output logic              bus_io
);

  logic cyc_active;
  logic wr_cycle;

  assign cyc_active = in_addr | in_strobe | in_release;
  assign wr_cycle   = cyc_active & is_write;

  always_comb begin
    bus_addr  = cyc_active ? mar : '0;
    bus_wdata = wr_cycle ? mdr : '0;
    bus_rd    = in_strobe & ~is_write;
    bus_wr    = in_strobe & is_write;
    bus_rnw   = ~wr_cycle;
    bus_io    = cyc_active & is_io;
  end

  // strobes are never both high (R3)
  always_comb begin
    assert_strobe_excl_R3: assert (!(bus_rd && bus_wr));
  end

endmodule

// File: rtl/mem_bus_seq.sv
module mem_bus_seq #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int IO_TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_rnw,
  output logic              bus_io,
  input  logic              bus_ready
);

  logic in_idle, in_addr, in_strobe, in_release;
  logic start, capture;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic is_write, is_io;

  assign start   = req_valid & in_idle;
  assign capture = in_strobe & bus_ready & ~is_write;

  mbs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tgt_ready  (bus_ready),
    .in_idle    (in_idle),
    .in_addr    (in_addr),
    .in_strobe  (in_strobe),
    .in_release (in_release)
  );

  mbs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_TAG_W(IO_TAG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .bus_rdata (bus_rdata),
    .mar       (mar),
    .mdr       (mdr),
    .is_write  (is_write),
    .is_io     (is_io)
  );

  mbs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .in_addr    (in_addr),
    .in_strobe  (in_strobe),
    .in_release (in_release),
    .mar        (mar),
    .mdr        (mdr),
    .is_write   (is_write),
    .is_io      (is_io),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rnw    (bus_rnw),
    .bus_io     (bus_io)
  );

  assign req_ready = in_idle;
  assign done      = in_release;
  assign rdata     = mdr;

  // ready only falls after an accepted request (R2)
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  // read strobe rises only after the same address was already driven (R3)
  assert_rd_after_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> (bus_addr == $past(bus_addr)) && !$past(bus_wr));

  // read data taken at the last strobe cycle, shown with done (R4)
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd) |-> done && (rdata == $past(bus_rdata)));

  // write strobe drops while address and data stay (R6)
  assert_wr_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr) |-> (bus_addr == $past(bus_addr)) && (bus_wdata == $past(bus_wdata)) && !bus_rnw);

  // data bus quiet outside stores (R8)
  assert_wdata_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rnw |-> (bus_wdata == '0));

  // done is a single pulse (R11)
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

endmodule

// File: tb/tb_mem_bus_seq.sv
module tb_mem_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, bus_rnw, bus_io, bus_ready;

  int checks = 0;
  int errors = 0;
  int wait_req = 0;
  int wait_cnt = 0;
  bit finished = 0;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
  } item_t;
  item_t sb[$];

  logic [7:0] mem  [0:255];
  logic [7:0] refm [0:255];

  always #5 clk = ~clk;

  mem_bus_seq dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rnw(bus_rnw), .bus_io(bus_io), .bus_ready(bus_ready)
  );

  // behavioural target: memory cells and I/O ports share one array by low address byte
  assign bus_ready = (wait_cnt == 0);
  assign bus_rdata = bus_rd ? mem[bus_addr[7:0]] : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 3 + 1);
      wait_cnt <= 0;
    end else begin
      if (bus_wr && bus_ready) mem[bus_addr[7:0]] <= bus_wdata;
      if (bus_rd || bus_wr) begin
        if (wait_cnt != 0) wait_cnt <= wait_cnt - 1;
      end else begin
        wait_cnt <= wait_req;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected item at each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R11 done without request", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.wr ? "R4 mdr after store" : "R4 R10 fetched data", {24'h0, rdata}, {24'h0, it.data});
      end
    end
  end

  task automatic issue(input logic wr, input logic [15:0] addr, input logic [7:0] data,
                       input int waits, input bit noise);
    logic [7:0] expd;
    logic       exp_io;
    exp_io = &addr[15:12];
    wait_req = waits;
    @(negedge clk);
    chk("R2 ready before request", {31'h0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    if (wr) begin refm[addr[7:0]] = data; expd = data; end
    else expd = refm[addr[7:0]];
    sb.push_back('{wr: wr, addr: addr, data: expd});
    @(negedge clk); // setup cycle
    if (noise) begin
      req_addr = addr ^ 16'h0101; req_write = ~wr; req_wdata = ~data;
    end else begin
      req_valid = 1'b0;
    end
    chk(wr ? "R5 setup address" : "R3 setup address", {16'h0, bus_addr}, {16'h0, addr});
    chk("R3 no strobe in setup", {30'h0, bus_rd, bus_wr}, 32'd0);
    chk(wr ? "R5 setup data" : "R8 no data on fetch", {24'h0, bus_wdata}, wr ? {24'h0, data} : 32'd0);
    chk("R9 rnw", {31'h0, bus_rnw}, {31'h0, ~wr});
    chk("R9 io flag", {31'h0, bus_io}, {31'h0, exp_io});
    chk("R2 busy", {31'h0, req_ready}, 32'd0);
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk);
      chk("R7 strobe held", {30'h0, bus_rd, bus_wr}, wr ? 32'd1 : 32'd2);
      chk(noise ? "R2 ignored request" : "R3 address held", {16'h0, bus_addr}, {16'h0, addr});
      chk("R7 no early done", {31'h0, done}, 32'd0);
    end
    @(negedge clk); // release cycle
    req_valid = 1'b0;
    chk("R6 strobe dropped", {30'h0, bus_rd, bus_wr}, 32'd0);
    chk("R6 address kept", {16'h0, bus_addr}, {16'h0, addr});
    chk("R6 data kept", {24'h0, bus_wdata}, wr ? {24'h0, data} : 32'd0);
    chk("R4 done in release", {31'h0, done}, 32'd1);
    @(negedge clk); // idle
    chk("R11 single done", {31'h0, done}, 32'd0);
    chk("R11 ready back", {31'h0, req_ready}, 32'd1);
    chk("R11 bus idle", {16'h0, bus_addr}, 32'd0);
    chk("R8 data idle", {24'h0, bus_wdata}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refm[i] = 8'(i * 3 + 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ready", {31'h0, req_ready}, 32'd1);
    chk("R1 done", {31'h0, done}, 32'd0);
    chk("R1 strobes", {30'h0, bus_rd, bus_wr}, 32'd0);
    chk("R1 bus addr", {16'h0, bus_addr}, 32'd0);
    chk("R1 bus data", {24'h0, bus_wdata}, 32'd0);

    issue(1'b0, 16'h0012, 8'h00, 0, 0);   // plain fetch
    issue(1'b1, 16'h0012, 8'hA7, 0, 0);   // R10 overwrite
    issue(1'b0, 16'h0012, 8'h00, 0, 0);   // R10 new value
    issue(1'b0, 16'h0012, 8'h00, 0, 0);   // R10 fetch is non-destructive
    issue(1'b1, 16'hF0A5, 8'h3C, 0, 0);   // R9 I/O store
    issue(1'b0, 16'hF0A5, 8'h00, 2, 0);   // R9 I/O fetch, R7 two waits
    issue(1'b1, 16'h0140, 8'h5E, 3, 0);   // R7 store with waits
    issue(1'b0, 16'h0140, 8'h00, 0, 1);   // R2 noise while busy
    issue(1'b0, 16'h0141, 8'h00, 0, 0);   // R2 neighbour untouched by noise
    issue(1'b1, 16'hEFFF, 8'hFF, 1, 1);   // R9 just below I/O region, noisy store
    issue(1'b0, 16'hEFFF, 8'h00, 0, 0);
    issue(1'b0, 16'h01FE, 8'h00, 0, 0);   // R2 cell flipped by noise address untouched

    repeat (2) @(negedge clk);
    chk("R11 scoreboard drained", sb.size(), 32'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule